// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block places frames from an upstream receiver into a ring of receive descriptors held in host memory. When a frame header (its byte count) is offered, the block walks the ring from its saved position, reading each descriptor's flag byte. It stops at the first descriptor whose flag byte shows that the host has handed it over, with no other flag set. It then records the received length in that descriptor, copies the frame bytes into the buffer belonging to that slot, and finally releases the descriptor back to the host.

All memory traffic goes through one byte-wide request port. A request stays posted until the memory raises its ready. The descriptor ring and the buffer area each start at a base address given on input ports, and every slot owns one fixed-size buffer. When no slot is free, or the controller is held stopped, the frame bytes are still taken from the upstream side, but they are discarded.

Top module: `rxr_ring_writer`

## Requirements
- R1: After a synchronous reset, `rx_index` is 0, `mem_req`, `rx_done` and `intr_pend` are low, and `frm_ready` is high.
- R2: A frame accepted while `ctl_stopped` is high has all of its bytes consumed. It causes no memory request, no `rx_done` pulse and no change of `rx_index`.
- R3: Descriptor i begins at `ring_base + 8*i`, and its flag byte sits at offset 2. A slot counts as free only when that byte equals exactly 0x80, so values such as 0x81 or 0xC0 are skipped.
- R4: The search reads flag bytes in ascending slot order, modulo 16, beginning at `rx_index`. It never reads slot `rx_index-1`, so at most 15 slots are read. If none of them is free, the frame is consumed with no write, no event and no change of index.
- R5: In the chosen slot, frame length plus 4 is written as two bytes, before any data: the high byte at descriptor offset 6 and the low byte at offset 7.
- R6: Frame byte k is written to `buf_base + slot*1544 + k`, in ascending k.
- R7: The last write for a stored frame is 0x03 to the slot's flag byte.
- R8: After a stored frame, `rx_index` becomes slot+1 and `rx_done` is high for exactly one cycle. `intr_pend` is set and stays set until `intr_ack` clears it.
- R9: While `mem_req` is high and `mem_ready` is low, the request, its address, its write flag and its write data stay unchanged into the next cycle.
- R10: A zero-length frame that finds a free slot writes the length value 4 and the flag byte 0x03, and no data bytes.
- R11: `rx_index` wraps from 15 to 0 after a store in slot 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 32 | Byte address of descriptor 0 |
| buf_base | input | 32 | Byte address of the buffer for slot 0 |
| ctl_stopped | input | 1 | Controller stopped; frames are discarded |
| frm_valid | input | 1 | A frame header is offered |
| frm_len | input | 11 | Byte count of the offered frame |
| frm_ready | output | 1 | Header accepted on this cycle when frm_valid is high |
| dat_valid | input | 1 | Frame byte valid |
| dat_byte | input | 8 | Frame byte |
| dat_ready | output | 1 | Frame byte taken on this cycle when dat_valid is high |
| mem_req | output | 1 | Memory request posted |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request completes on this cycle |
| rx_done | output | 1 | One-cycle pulse after a frame is stored |
| intr_pend | output | 1 | Sticky receive interrupt summary |
| intr_ack | input | 1 | Clears intr_pend |
| rx_index | output | 4 | Slot where the next search starts |

## Verification
Frames of several lengths, including zero and one byte, are sent against flag tables filled with different non-free values: 0x00, 0x81 and 0xC0. The 0x81 and 0xC0 tables show that only an exact 0x80 counts as free. Free slots are placed in three positions: at the search start, at the last slot the search is allowed to read, and at the one slot just outside its window. Together these separate the case of a slot being found from the case of a frame being dropped, and they show where the window ends. One store lands in the top slot to show the index wrapping. A frame sent while the controller is stopped, with every slot free, shows that the stop alone suppresses all memory traffic. The memory answers on alternate cycles, so requests are left waiting and can be checked for holding steady.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DRAIN, ST_SEEK, ST_LEN_HI, ST_LEN_LO, ST_GET, ST_PUT, ST_FLAG
  } rxr_state_e;

  typedef enum logic [1:0] {
    FLD_FLAG, FLD_MLEN_HI, FLD_MLEN_LO, FLD_DATA
  } rxr_field_e;

  localparam logic [7:0] FLAG_OWNED    = 8'h80;
  localparam logic [7:0] FLAG_COMPLETE = 8'h03;
  localparam int DESC_BYTES = 8;
  localparam int OFS_FLAG   = 2;
  localparam int OFS_MLEN   = 6;
  localparam int MLEN_PAD   = 4;
  localparam int MLEN_W     = 16;
endpackage

// File: rtl/rxr_addr_gen.sv
module rxr_addr_gen
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SLOT_W    = 4,
  parameter int OFF_W     = 11,
  parameter int BUF_BYTES = 1544
) (
  input  logic [AW-1:0]     ring_base,
  input  logic [AW-1:0]     buf_base,
  input  logic [SLOT_W-1:0] slot,
  input  rxr_field_e        field,
  input  logic [OFF_W-1:0]  off,
  output logic [AW-1:0]     addr
);
  localparam int IS_POW2 = ((BUF_BYTES & (BUF_BYTES - 1)) == 0) ? 1 : 0;
  localparam int BUF_SH  = $clog2(BUF_BYTES);
  localparam int DESC_SH = $clog2(DESC_BYTES);

  logic [AW-1:0] desc_start;
  logic [AW-1:0] buf_start;

  assign desc_start = ring_base + (AW'(slot) << DESC_SH);

  // Buffer stride: a shift when the size is a power of two, else a constant multiply.
  generate
    if (IS_POW2 != 0) begin : g_shift
      assign buf_start = buf_base + (AW'(slot) << BUF_SH);
    end else begin : g_mul
      assign buf_start = buf_base + AW'(slot) * AW'(BUF_BYTES);
    end
  endgenerate

  always_comb begin
    case (field)
      FLD_FLAG:    addr = desc_start + AW'(OFS_FLAG);
      FLD_MLEN_HI: addr = desc_start + AW'(OFS_MLEN);
      FLD_MLEN_LO: addr = desc_start + AW'(OFS_MLEN + 1);
      default:     addr = buf_start + AW'(off);
    endcase
  end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              step,
  input  logic              commit,
  output logic [SLOT_W-1:0] index,
  output logic [SLOT_W-1:0] cursor,
  output logic              last
);
  localparam int RING = 1 << SLOT_W;
  localparam logic [SLOT_W-1:0] LAST_CNT = SLOT_W'(RING - 2);

  logic [SLOT_W-1:0] index_q, cursor_q, cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q  <= '0;
      cursor_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (start) begin
        cursor_q <= index_q;
        cnt_q    <= '0;
      end else if (step) begin
        cursor_q <= cursor_q + SLOT_W'(1);
        cnt_q    <= cnt_q + SLOT_W'(1);
      end
      if (commit) index_q <= cursor_q + SLOT_W'(1);
    end
  end

  assign index  = index_q;
  assign cursor = cursor_q;
  assign last   = (cnt_q == LAST_CNT);

  // The window never reaches the slot just before the start point.
  assert_window_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_CNT);
  assert_no_step_past_end_R4: assert property (@(posedge clk) disable iff (rst)
    step |-> !last);
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_stopped,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  output logic             frm_ready,
  input  logic             dat_valid,
  input  logic [7:0]       dat_byte,
  output logic             dat_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_ready,
  output rxr_field_e       field,
  output logic [LEN_W-1:0] byte_off,
  output logic             ptr_start,
  output logic             ptr_step,
  output logic             ptr_commit,
  input  logic             ptr_last,
  output logic             rx_done,
  output logic             intr_pend,
  input  logic             intr_ack
);
  rxr_state_e        state_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [7:0]        byte_q;
  logic              done_q, intr_q;
  logic [MLEN_W-1:0] mlen;
  logic              last_byte;

  assign mlen      = MLEN_W'(len_q) + MLEN_W'(MLEN_PAD);
  assign last_byte = (LEN_W'(cnt_q + LEN_W'(1)) == len_q);

  assign frm_ready = (state_q == ST_IDLE);
  assign dat_ready = (state_q == ST_GET) || (state_q == ST_DRAIN);
  assign mem_req   = (state_q == ST_SEEK) || (state_q == ST_LEN_HI) ||
                     (state_q == ST_LEN_LO) || (state_q == ST_PUT) ||
                     (state_q == ST_FLAG);
  assign mem_we    = mem_req && (state_q != ST_SEEK);
  assign byte_off  = cnt_q;

  always_comb begin
    case (state_q)
      ST_SEEK, ST_FLAG: field = FLD_FLAG;
      ST_LEN_HI:        field = FLD_MLEN_HI;
      ST_LEN_LO:        field = FLD_MLEN_LO;
      default:          field = FLD_DATA;
    endcase
    case (state_q)
      ST_LEN_HI: mem_wdata = mlen[15:8];
      ST_LEN_LO: mem_wdata = mlen[7:0];
      ST_PUT:    mem_wdata = byte_q;
      ST_FLAG:   mem_wdata = FLAG_COMPLETE;
      default:   mem_wdata = 8'h00;
    endcase
  end

  assign ptr_start  = (state_q == ST_IDLE) && frm_valid;
  assign ptr_step   = (state_q == ST_SEEK) && mem_ready &&
                      (mem_rdata != FLAG_OWNED) && !ptr_last;
  assign ptr_commit = (state_q == ST_FLAG) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
      byte_q  <= '0;
      done_q  <= 1'b0;
      intr_q  <= 1'b0;
    end else begin
      done_q <= ptr_commit;
      if (ptr_commit)    intr_q <= 1'b1;
      else if (intr_ack) intr_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (frm_valid) begin
          len_q <= frm_len;
          cnt_q <= '0;
          if (ctl_stopped) state_q <= (frm_len == '0) ? ST_IDLE : ST_DRAIN;
          else             state_q <= ST_SEEK;
        end
        ST_SEEK: if (mem_ready) begin
          if (mem_rdata == FLAG_OWNED) state_q <= ST_LEN_HI;
          else if (ptr_last)           state_q <= (len_q == '0) ? ST_IDLE : ST_DRAIN;
        end
        ST_LEN_HI: if (mem_ready) state_q <= ST_LEN_LO;
        ST_LEN_LO: if (mem_ready) state_q <= (len_q == '0) ? ST_FLAG : ST_GET;
        ST_GET: if (dat_valid) begin
          byte_q  <= dat_byte;
          state_q <= ST_PUT;
        end
        ST_PUT: if (mem_ready) begin
          cnt_q   <= cnt_q + LEN_W'(1);
          state_q <= last_byte ? ST_FLAG : ST_GET;
        end
        ST_FLAG: if (mem_ready) state_q <= ST_IDLE;
        ST_DRAIN: if (dat_valid) begin
          cnt_q <= cnt_q + LEN_W'(1);
          if (last_byte) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_done   = done_q;
  assign intr_pend = intr_q;

  assert_stop_no_access_R2: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_ready && ctl_stopped) |=> !mem_req);
  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata)));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (intr_ack && !ptr_commit) |=> !intr_pend);
  assert_done_sets_intr_R8: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> intr_pend);
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int RING_LOG  = 4,
  parameter int LEN_W     = 11,
  parameter int BUF_BYTES = 1544
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       ring_base,
  input  logic [AW-1:0]       buf_base,
  input  logic                ctl_stopped,
  input  logic                frm_valid,
  input  logic [LEN_W-1:0]    frm_len,
  output logic                frm_ready,
  input  logic                dat_valid,
  input  logic [7:0]          dat_byte,
  output logic                dat_ready,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [7:0]          mem_wdata,
  input  logic [7:0]          mem_rdata,
  input  logic                mem_ready,
  output logic                rx_done,
  output logic                intr_pend,
  input  logic                intr_ack,
  output logic [RING_LOG-1:0] rx_index
);
  rxr_field_e          field;
  logic [LEN_W-1:0]    byte_off;
  logic                ptr_start, ptr_step, ptr_commit, ptr_last;
  logic [RING_LOG-1:0] cursor;

  rxr_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctl_stopped(ctl_stopped),
    .frm_valid(frm_valid), .frm_len(frm_len), .frm_ready(frm_ready),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_ready(dat_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .field(field), .byte_off(byte_off),
    .ptr_start(ptr_start), .ptr_step(ptr_step), .ptr_commit(ptr_commit),
    .ptr_last(ptr_last),
    .rx_done(rx_done), .intr_pend(intr_pend), .intr_ack(intr_ack)
  );

  rxr_ring_ptr #(.SLOT_W(RING_LOG)) u_ptr (
    .clk(clk), .rst(rst), .start(ptr_start), .step(ptr_step),
    .commit(ptr_commit), .index(rx_index), .cursor(cursor), .last(ptr_last)
  );

  rxr_addr_gen #(.AW(AW), .SLOT_W(RING_LOG), .OFF_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_addr (
    .ring_base(ring_base), .buf_base(buf_base), .slot(cursor),
    .field(field), .off(byte_off), .addr(mem_addr)
  );

  assert_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> $stable(mem_addr));
  assert_done_moves_index_R8: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> (rx_index != $past(rx_index)));
endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
  localparam int AW = 32;
  localparam int LEN_W = 11;
  localparam int BUFB = 1544;
  localparam logic [AW-1:0] RB = 32'h0000_1000;
  localparam logic [AW-1:0] BB = 32'h0002_0000;
  localparam int LOGN = 512;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_stopped = 1'b0, frm_valid = 1'b0, dat_valid = 1'b0, intr_ack = 1'b0;
  logic [LEN_W-1:0] frm_len = '0;
  logic [7:0] dat_byte = '0;
  logic frm_ready, dat_ready, mem_req, mem_we, rx_done, intr_pend;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_ready = 1'b0;
  logic [3:0] rx_index;

  always #2 clk = ~clk;

  rxr_ring_writer u0 (
    .clk(clk), .rst(rst), .ring_base(RB), .buf_base(BB), .ctl_stopped(ctl_stopped),
    .frm_valid(frm_valid), .frm_len(frm_len), .frm_ready(frm_ready),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_ready(dat_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rx_done(rx_done),
    .intr_pend(intr_pend), .intr_ack(intr_ack), .rx_index(rx_index)
  );

  // Memory model: flag table for reads, logs of every completed access.
  logic [7:0] flag_tab [16];
  logic [AW-1:0] rel;
  assign rel = mem_addr - RB;
  assign mem_rdata = (rel < 32'd128) ? flag_tab[rel[6:3]] : 8'h00;

  always @(posedge clk) mem_ready <= rst ? 1'b0 : ~mem_ready;

  int rd_n = 0, wr_n = 0, done_n = 0, hold_bad = 0;
  logic [3:0] rd_log [LOGN];
  logic [AW-1:0] wr_addr [LOGN];
  logic [7:0] wr_dat [LOGN];

  always @(posedge clk) begin
    if (!rst && mem_req && mem_ready) begin
      if (mem_we) begin
        if (wr_n < LOGN) begin wr_addr[wr_n] <= mem_addr; wr_dat[wr_n] <= mem_wdata; end
        wr_n <= wr_n + 1;
      end else begin
        if (rd_n < LOGN) rd_log[rd_n] <= rel[6:3];
        rd_n <= rd_n + 1;
      end
    end
  end

  logic pend_prev = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [7:0] prev_w;
  always @(negedge clk) begin
    if (rx_done) done_n <= done_n + 1;
    if (pend_prev && (!mem_req || mem_addr != prev_addr || mem_wdata != prev_w))
      hold_bad <= hold_bad + 1;
    pend_prev <= !rst && mem_req && !mem_ready;
    prev_addr <= mem_addr;
    prev_w    <= mem_wdata;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input int seed);
    frm_len = LEN_W'(len);
    frm_valid = 1'b1;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
    for (int k = 0; k < len; k++) begin
      dat_byte = 8'(seed + 7 * k);
      dat_valid = 1'b1;
      while (!dat_ready) @(negedge clk);
      @(negedge clk);
    end
    dat_valid = 1'b0;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  int exp_idx = 0;

  task automatic run_vec(input int len, input int free_slot, input logic [7:0] decoy, input int seed);
    int r0, w0, d0, slot, nrd;
    bit found, seq_ok, dat_ok;
    string lreq;
    for (int s = 0; s < 16; s++) flag_tab[s] = decoy;
    flag_tab[free_slot] = 8'h80;
    r0 = rd_n; w0 = wr_n; d0 = done_n;
    found = 1'b0; slot = 0; nrd = 15;
    for (int j = 0; j < 15; j++) begin
      if (!found && flag_tab[(exp_idx + j) % 16] == 8'h80) begin
        found = 1'b1; slot = (exp_idx + j) % 16; nrd = j + 1;
      end
    end
    send_frame(len, seed);
    chk(rd_n - r0 == nrd, "R4 flag reads", rd_n - r0, nrd);
    seq_ok = 1'b1;
    for (int j = 0; j < nrd && r0 + j < LOGN; j++)
      if (rd_log[r0 + j] != 4'((exp_idx + j) % 16)) seq_ok = 1'b0;
    chk(seq_ok, "R3 search order and exact match", int'(seq_ok), 1);
    if (found) begin
      lreq = (len == 0) ? "R10 write count" : "R6 write count";
      chk(wr_n - w0 == len + 3, lreq, wr_n - w0, len + 3);
      chk(wr_addr[w0] == RB + AW'(slot * 8 + 6) && wr_dat[w0] == 8'((len + 4) >> 8) &&
          wr_addr[w0 + 1] == RB + AW'(slot * 8 + 7) && wr_dat[w0 + 1] == 8'(len + 4),
          "R5 length bytes", int'({wr_dat[w0], wr_dat[w0 + 1]}), len + 4);
      dat_ok = 1'b1;
      for (int k = 0; k < len; k++)
        if (wr_addr[w0 + 2 + k] != BB + AW'(slot * BUFB + k) || wr_dat[w0 + 2 + k] != 8'(seed + 7 * k))
          dat_ok = 1'b0;
      chk(dat_ok, "R6 buffer bytes", int'(dat_ok), 1);
      chk(wr_addr[w0 + len + 2] == RB + AW'(slot * 8 + 2) && wr_dat[w0 + len + 2] == 8'h03,
          "R7 flag written last", int'(wr_dat[w0 + len + 2]), 3);
      chk(done_n - d0 == 1, "R8 done pulse count", done_n - d0, 1);
      exp_idx = (slot + 1) % 16;
      chk(int'(rx_index) == exp_idx, (slot == 15) ? "R11 index wrap" : "R8 index advance",
          int'(rx_index), exp_idx);
      chk(intr_pend == 1'b1, "R8 interrupt summary set", int'(intr_pend), 1);
    end else begin
      chk(wr_n - w0 == 0, "R4 no writes on drop", wr_n - w0, 0);
      chk(done_n - d0 == 0, "R4 no event on drop", done_n - d0, 0);
      chk(int'(rx_index) == exp_idx, "R4 index kept on drop", int'(rx_index), exp_idx);
    end
  endtask

  // {length[7:0], free slot[3:0], non-free flag value[7:0]}
  localparam logic [19:0] VECS [6] = '{
    {8'd5,  4'd0,  8'h00},
    {8'd12, 4'd3,  8'h81},
    {8'd1,  4'd2,  8'hC0},
    {8'd7,  4'd2,  8'h00},
    {8'd0,  4'd3,  8'h00},
    {8'd9,  4'd15, 8'h00}
  };

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int r0, w0, d0, ix;
    for (int s = 0; s < 16; s++) flag_tab[s] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rx_index == 4'd0, "R1 index after reset", int'(rx_index), 0);
    chk(!mem_req && !rx_done, "R1 no request or event", int'({mem_req, rx_done}), 0);
    chk(!intr_pend && frm_ready, "R1 pending low, ready high", int'({intr_pend, frm_ready}), 1);

    for (int v = 0; v < 6; v++) begin
      run_vec(int'(VECS[v][19:12]), int'(VECS[v][11:8]), VECS[v][7:0], 16 * v + 3);
      if (v == 0) begin
        // R8: summary holds until acknowledged
        repeat (3) @(negedge clk);
        chk(intr_pend == 1'b1, "R8 pending holds", int'(intr_pend), 1);
        intr_ack = 1'b1;
        @(negedge clk);
        intr_ack = 1'b0;
        @(negedge clk);
        chk(intr_pend == 1'b0, "R8 ack clears pending", int'(intr_pend), 0);
      end
    end

    // R2: stopped controller, every slot free
    for (int s = 0; s < 16; s++) flag_tab[s] = 8'h80;
    ctl_stopped = 1'b1;
    r0 = rd_n; w0 = wr_n; d0 = done_n; ix = int'(rx_index);
    send_frame(6, 200);
    chk(rd_n == r0 && wr_n == w0, "R2 no memory access", (rd_n - r0) + (wr_n - w0), 0);
    chk(done_n == d0 && int'(rx_index) == ix, "R2 no event, index kept", int'(rx_index), ix);
    chk(frm_ready == 1'b1 && dat_ready == 1'b0, "R2 frame fully consumed",
        int'({frm_ready, dat_ready}), 2);
    ctl_stopped = 1'b0;

    chk(hold_bad == 0, "R9 request held while waiting", hold_bad, 0);
    finish_run();
  end
endmodule